// File: doc/BRIEF.md
# Port Status LED Controller

This block turns the status of one network port into three lamp drive levels: a link lamp, an activity lamp and a lamp whose meaning depends on the duplex mode. In full duplex that third lamp stays on. In half duplex it shows collisions and flashes while the transmitter is jabbering. All lamp outputs are active low: a 0 lights the lamp.

Short activity and collision strobes are stretched so the eye can see them. Each strobe holds its lamp on for a minimum time. A new strobe inside that window restarts it, so steady traffic gives a steady lamp. After reset releases, every lamp lights for a lamp-test interval and then normal display begins.

All times are counted in periods of an external millisecond tick and set by parameters. A bench can shorten them.

Top module: `port_led_ctrl`

## Requirements
- R1: While `rst_n` is low, all three outputs are 1 (lamps dark); outputs are active low throughout, 0 meaning lit.
- R2: From the first clock edge after `rst_n` rises, all three outputs are 0 until `LAMP_TICKS` tick pulses have been counted; the clock edge that samples the last of them ends the test.
- R3: After the lamp test, `led_link_n` is the inverse of `link_up`.
- R4: A clock edge that samples `tx_act` or `rx_act` high makes `led_act_n` 0 from that edge on. It stays 0 until `STRETCH_TICKS` further tick pulses have been sampled with no new activity, and then returns to 1.
- R5: Activity sampled again inside the window restarts the full `STRETCH_TICKS` count, also when it arrives in the same cycle as a tick.
- R6: With `full_duplex` high after the lamp test, `led_dupcol_n` is 0 continuously, whatever `collision` and `jabber` do.
- R7: In half duplex, a sampled `collision` lights `led_dupcol_n` from that edge for `STRETCH_TICKS` ticks, and a repeated collision restarts the count.
- R8: In half duplex with `jabber` high and no collision stretch running, `led_dupcol_n` is 0 for the first `FLASH_TICKS` ticks, 1 for the next `FLASH_TICKS`, and alternates from then on. Each rise of `jabber` restarts the pattern lit.
- R9: In half duplex with `jabber` low and no collision stretch running, `led_dupcol_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-cycle pulse per timebase period (1 ms nominal) |
| link_up | input | 1 | Port has a valid link |
| tx_act | input | 1 | Transmit activity strobe |
| rx_act | input | 1 | Receive activity strobe |
| collision | input | 1 | Collision strobe |
| full_duplex | input | 1 | Port runs full duplex |
| jabber | input | 1 | Transmit jabber condition present |
| led_link_n | output | 1 | Link lamp, active low |
| led_act_n | output | 1 | Activity lamp, active low |
| led_dupcol_n | output | 1 | Duplex/collision lamp, active low |

## Verification
On every cycle, the assertions check four things: the dark lamps during reset, the all-on lamp test, the link lamp following the link level, and the steady duplex lamp in full duplex. They also check that an activity or collision strobe lights its lamp at the next edge, and that the stretch counters never pass their load value. Only the bench scenarios can show the time-dependent parts. These are the exact tick at which a stretched lamp goes dark, the restart of a window by a late strobe, and the phase of the jabber flash across many periods.

// File: rtl/port_led_ctrl.sv
module port_led_ctrl #(
  parameter int LAMP_TICKS    = 100,
  parameter int STRETCH_TICKS = 20,
  parameter int FLASH_TICKS   = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic link_up,
  input  logic tx_act,
  input  logic rx_act,
  input  logic collision,
  input  logic full_duplex,
  input  logic jabber,
  output logic led_link_n,
  output logic led_act_n,
  output logic led_dupcol_n
);
  localparam int LW = $clog2(LAMP_TICKS + 1);
  localparam int SW = $clog2(STRETCH_TICKS + 1);
  localparam int FW = $clog2(FLASH_TICKS + 1);
  localparam logic [LW-1:0] LAMP_LAST = LW'(LAMP_TICKS - 1);
  localparam logic [SW-1:0] STR_LOAD  = SW'(STRETCH_TICKS);
  localparam logic [FW-1:0] FLASH_LAST = FW'(FLASH_TICKS - 1);

  logic          live_q, test_q, flash_on;
  logic [LW-1:0] test_cnt;
  logic [SW-1:0] act_cnt, col_cnt;
  logic [FW-1:0] flash_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q   <= 1'b0;
      test_q   <= 1'b1;
      test_cnt <= '0;
    end else begin
      live_q <= 1'b1;
      if (test_q && ms_tick) begin
        if (test_cnt == LAMP_LAST) test_q <= 1'b0;
        else test_cnt <= test_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_cnt <= '0;
      col_cnt <= '0;
    end else begin
      if (tx_act || rx_act)           act_cnt <= STR_LOAD;
      else if (ms_tick && act_cnt != 0) act_cnt <= act_cnt - 1'b1;
      if (collision)                  col_cnt <= STR_LOAD;
      else if (ms_tick && col_cnt != 0) col_cnt <= col_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flash_cnt <= '0;
      flash_on  <= 1'b1;
    end else if (!jabber) begin
      flash_cnt <= '0;
      flash_on  <= 1'b1;
    end else if (ms_tick) begin
      if (flash_cnt == FLASH_LAST) begin
        flash_cnt <= '0;
        flash_on  <= ~flash_on;
      end else begin
        flash_cnt <= flash_cnt + 1'b1;
      end
    end
  end

  wire show_test = live_q && test_q;
  wire show_norm = live_q && !test_q;
  wire dupcol_on = full_duplex || col_cnt != 0 || (jabber && flash_on);

  assign led_link_n   = !(show_test || (show_norm && link_up));
  assign led_act_n    = !(show_test || (show_norm && act_cnt != 0));
  assign led_dupcol_n = !(show_test || (show_norm && dupcol_on));
endmodule

// File: rtl/port_led_ctrl_chk.sv
module port_led_ctrl_chk #(
  parameter int STRETCH_TICKS = 20,
  parameter int SW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          live_q,
  input logic          test_q,
  input logic          link_up,
  input logic          tx_act,
  input logic          rx_act,
  input logic          collision,
  input logic          full_duplex,
  input logic [SW-1:0] act_cnt,
  input logic [SW-1:0] col_cnt,
  input logic          led_link_n,
  input logic          led_act_n,
  input logic          led_dupcol_n
);
  a_r1_dark_in_reset: assert property (@(posedge clk)
    !rst_n |-> (led_link_n && led_act_n && led_dupcol_n));

  a_r2_lamp_test_all_on: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && test_q) |-> (!led_link_n && !led_act_n && !led_dupcol_n));

  a_r3_link_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !test_q) |-> (led_link_n == !link_up));

  a_r4_act_lights_next: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_act || rx_act) |=> !led_act_n);

  a_r5_act_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    act_cnt <= SW'(STRETCH_TICKS));

  a_r6_fdx_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && full_duplex) |-> !led_dupcol_n);

  a_r7_col_lights_next: assert property (@(posedge clk) disable iff (!rst_n)
    collision |=> !led_dupcol_n);

  a_r7_col_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    col_cnt <= SW'(STRETCH_TICKS));
endmodule

bind port_led_ctrl port_led_ctrl_chk #(
  .STRETCH_TICKS(STRETCH_TICKS),
  .SW(SW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .live_q(live_q), .test_q(test_q),
  .link_up(link_up), .tx_act(tx_act), .rx_act(rx_act),
  .collision(collision), .full_duplex(full_duplex),
  .act_cnt(act_cnt), .col_cnt(col_cnt),
  .led_link_n(led_link_n), .led_act_n(led_act_n), .led_dupcol_n(led_dupcol_n)
);

// File: tb/port_led_ctrl_tb_top.sv
`timescale 1ns/1ps
module port_led_ctrl_tb_top;
  localparam int LAMP = 10, STR = 4, FLASH = 3;

  logic clk = 1'b0, rst_n = 1'b0, ms_tick = 1'b0;
  logic link_up = 1'b0, tx_act = 1'b0, rx_act = 1'b0;
  logic collision = 1'b0, full_duplex = 1'b0, jabber = 1'b0;
  logic led_link_n, led_act_n, led_dupcol_n;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  port_led_ctrl #(.LAMP_TICKS(LAMP), .STRETCH_TICKS(STR), .FLASH_TICKS(FLASH)) dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .link_up(link_up),
    .tx_act(tx_act), .rx_act(rx_act), .collision(collision),
    .full_duplex(full_duplex), .jabber(jabber),
    .led_link_n(led_link_n), .led_act_n(led_act_n), .led_dupcol_n(led_dupcol_n));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1; step(); ms_tick = 1'b0;
    end
  endtask

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    link_up = 1'b1;
    repeat (3) step();
    // R1: reset keeps every lamp dark
    check("R1 link", led_link_n, 1'b1);
    check("R1 act", led_act_n, 1'b1);
    check("R1 dupcol", led_dupcol_n, 1'b1);
    link_up = 1'b0;
    rst_n = 1'b1;
    step();
    // R2: lamp test all on
    check("R2 link", led_link_n, 1'b0);
    check("R2 act", led_act_n, 1'b0);
    check("R2 dupcol", led_dupcol_n, 1'b0);
    tick(LAMP - 1);
    check("R2 still on", led_link_n & led_act_n & led_dupcol_n, 1'b0);
    tick(1);
    check("R2 end act", led_act_n, 1'b1);
    check("R2 end dupcol", led_dupcol_n, 1'b1);

    // R3: link sweep
    for (int l = 0; l < 2; l++) begin
      link_up = l[0]; step();
      check("R3 link", led_link_n, ~l[0]);
    end
    link_up = 1'b0;

    // R4: stretch length, both sources
    for (int src = 0; src < 2; src++) begin
      if (src == 0) tx_act = 1'b1; else rx_act = 1'b1;
      step(); tx_act = 1'b0; rx_act = 1'b0;
      check("R4 lit", led_act_n, 1'b0);
      for (int k = 1; k <= STR; k++) begin
        tick(1);
        check("R4 window", led_act_n, (k == STR));
      end
    end

    // R5: retrigger inside window, and strobe coinciding with a tick
    tx_act = 1'b1; step(); tx_act = 1'b0;
    tick(2);
    rx_act = 1'b1; ms_tick = 1'b1; step(); rx_act = 1'b0; ms_tick = 1'b0;
    tick(STR - 1);
    check("R5 restarted", led_act_n, 1'b0);
    tick(1);
    check("R5 expired", led_act_n, 1'b1);

    // R9: half duplex idle is dark
    step();
    check("R9 idle", led_dupcol_n, 1'b1);

    // R7: collision stretch with retrigger
    collision = 1'b1; step(); collision = 1'b0;
    check("R7 lit", led_dupcol_n, 1'b0);
    tick(STR - 1);
    collision = 1'b1; step(); collision = 1'b0;
    tick(STR - 1);
    check("R7 restarted", led_dupcol_n, 1'b0);
    tick(1);
    check("R7 expired", led_dupcol_n, 1'b1);

    // R8: jabber flash pattern over several periods
    jabber = 1'b1; step();
    check("R8 start lit", led_dupcol_n, 1'b0);
    for (int k = 1; k <= 4 * FLASH; k++) begin
      tick(1);
      check("R8 flash", led_dupcol_n, ((k / FLASH) % 2) == 1);
    end
    jabber = 1'b0; step();
    check("R9 jabber gone", led_dupcol_n, 1'b1);
    jabber = 1'b1; step();
    check("R8 restart lit", led_dupcol_n, 1'b0);
    jabber = 1'b0; step();

    // R6: full duplex steady under every collision/jabber mix
    full_duplex = 1'b1;
    for (int m = 0; m < 4; m++) begin
      collision = m[0]; jabber = m[1];
      for (int k = 0; k < 2 * FLASH + STR; k++) begin
        tick(1); collision = 1'b0;
        check("R6 steady", led_dupcol_n, 1'b0);
      end
    end
    jabber = 1'b0; full_duplex = 1'b0;
    tick(STR);
    check("R9 back to half", led_dupcol_n, 1'b1);

    finish_run();
  end
endmodule